// File: doc/BRIEF.md
# Midpoint Feature Triple Detector

The block watches a one-dimensional map of `N` locations. Every location carries three binary feature flags, presented in parallel on the vectors `feat_a`, `feat_b` and `feat_c`. The block raises `found` when some location holding feature A and some location holding feature B have a location with feature C exactly halfway between them. This relation does not change when the pattern is shifted along the map or stretched, so the block is a building unit for position-independent and size-independent pattern detection. A two-dimensional detector can be built from instances of it, one per axis.

Only integer midpoints count. A pair whose index sum is odd has no midpoint and is skipped. The two end points may come in either order, and may coincide. When a match exists, the block reports one witness triple: the A location, the B location and the C location. A fixed priority picks which triple is reported. The result goes through one register stage, so it appears one clock after the inputs are sampled.

Top module: `midpoint_triple_detect`

## Requirements
- R1: `found` is 1 one clock edge after the inputs are sampled exactly when there exist i, j with feat_a[i]=1, feat_b[j]=1, i+j even and feat_c[(i+j)/2]=1.
- R2: A pair whose index sum i+j is odd never produces a match, even when feat_c is 1 at every location.
- R3: The order of the end points is unrestricted: a match counts with the A location left of the B location and with it right of the B location.
- R4: i = j is allowed; all three flags set at one location is a match with witness (i, i, i).
- R5: When `found` is 1, the witness satisfies feat_a[wit_a]=1, feat_b[wit_b]=1, feat_c[wit_c]=1 and wit_a + wit_b = 2*wit_c, against the inputs sampled at the previous edge.
- R6: Witness priority: lowest center wit_c first; within that center, smallest half-distance d = |wit_a - wit_c|; at equal d, the orientation with the A location at the lower index (wit_a = wit_c - d) wins over wit_a = wit_c + d.
- R7: When `found` is 0, `wit_a`, `wit_b` and `wit_c` are all 0.
- R8: While `rst` is high at a clock edge, all outputs are 0 after that edge.
- R9: Outputs are registered: each input pattern is reflected after exactly one rising edge and held until the next.
- R10: Pairs at the map boundaries are detected, including end points at index 0 and index N-1 (for example A at 0, B at N-2, C at (N-2)/2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| feat_a | input | N | Feature A flag per location |
| feat_b | input | N | Feature B flag per location |
| feat_c | input | N | Feature C flag per location |
| found | output | 1 | A midpoint triple exists (registered) |
| wit_a | output | log2 N | Location of the reported A end point |
| wit_b | output | log2 N | Location of the reported B end point |
| wit_c | output | log2 N | Location of the reported midpoint |

## Verification
The first sweep sets a single A flag and a single B flag over every ordered pair of locations, with C set everywhere. Whether `found` rises then separates even index sums from odd ones. It also shows that both end-point orders and coinciding end points are accepted, and the reported center follows directly from the pair. The second sweep keeps the same pairs but sets C at one location only, one above the true midpoint. This catches a midpoint computed with the wrong rounding or offset. Pseudo-random dense and sparse patterns with several candidate triples are then compared against a brute-force search that applies the stated priority, which checks the choice of center, distance and orientation. Hand-picked cases cover the map ends and reset.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

    // Which way round the end points of a candidate pair lie
    typedef enum logic {
        ORI_A_LOW  = 1'b0,   // A location below the center
        ORI_A_HIGH = 1'b1    // A location above the center
    } orient_e;

    // Largest half-distance that stays on the map around center k
    function automatic int max_reach(input int n, input int k);
        return (k < (n - 1 - k)) ? k : (n - 1 - k);
    endfunction

endpackage

// File: rtl/mtd_center.sv
module mtd_center
    import mtd_pkg::*;
#(
    parameter int N  = 16,
    parameter int K  = 0,
    parameter int IW = 4
) (
    input  logic [N-1:0]  feat_a,
    input  logic [N-1:0]  feat_b,
    input  logic          c_here,
    output logic          hit,
    output logic [IW-1:0] off,
    output orient_e       ori
);
    localparam int REACH = max_reach(N, K);

    logic any;

    always_comb begin
        any = 1'b0;
        off = '0;
        ori = ORI_A_LOW;
        for (int d = 0; d <= REACH; d++) begin
            if (!any) begin
                if (feat_a[K-d] && feat_b[K+d]) begin
                    any = 1'b1;
                    off = IW'(d);
                    ori = ORI_A_LOW;
                end else if (feat_a[K+d] && feat_b[K-d]) begin
                    any = 1'b1;
                    off = IW'(d);
                    ori = ORI_A_HIGH;
                end
            end
        end
        hit = any & c_here;
    end
endmodule

// File: rtl/mtd_select.sv
module mtd_select
    import mtd_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]         hit_v,
    input  logic [N-1:0][IW-1:0] off_v,
    input  logic [N-1:0]         high_v,
    output logic                 any,
    output logic [IW-1:0]        pos_a,
    output logic [IW-1:0]        pos_b,
    output logic [IW-1:0]        pos_c
);
    always_comb begin
        any   = 1'b0;
        pos_a = '0;
        pos_b = '0;
        pos_c = '0;
        // descending scan: the last hit written is the lowest center
        for (int k = N - 1; k >= 0; k--) begin
            if (hit_v[k]) begin
                any   = 1'b1;
                pos_c = IW'(k);
                if (high_v[k]) begin
                    pos_a = IW'(k) + off_v[k];
                    pos_b = IW'(k) - off_v[k];
                end else begin
                    pos_a = IW'(k) - off_v[k];
                    pos_b = IW'(k) + off_v[k];
                end
            end
        end
    end
endmodule

// File: rtl/midpoint_triple_detect.sv
module midpoint_triple_detect
    import mtd_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         feat_a,
    input  logic [N-1:0]         feat_b,
    input  logic [N-1:0]         feat_c,
    output logic                 found,
    output logic [$clog2(N)-1:0] wit_a,
    output logic [$clog2(N)-1:0] wit_b,
    output logic [$clog2(N)-1:0] wit_c
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic          hit;
        logic [IW-1:0] a;
        logic [IW-1:0] b;
        logic [IW-1:0] c;
    } witness_t;

    logic [N-1:0]         hit_v;
    logic [N-1:0][IW-1:0] off_v;
    logic [N-1:0]         high_v;
    witness_t             nxt, cur;

    for (genvar k = 0; k < N; k++) begin : g_center
        orient_e ori_k;
        mtd_center #(.N(N), .K(k), .IW(IW)) u_center (
            .feat_a (feat_a),
            .feat_b (feat_b),
            .c_here (feat_c[k]),
            .hit    (hit_v[k]),
            .off    (off_v[k]),
            .ori    (ori_k)
        );
        assign high_v[k] = (ori_k == ORI_A_HIGH);
    end

    mtd_select #(.N(N), .IW(IW)) u_select (
        .hit_v  (hit_v),
        .off_v  (off_v),
        .high_v (high_v),
        .any    (nxt.hit),
        .pos_a  (nxt.a),
        .pos_b  (nxt.b),
        .pos_c  (nxt.c)
    );

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign found = cur.hit;
    assign wit_a = cur.a;
    assign wit_b = cur.b;
    assign wit_c = cur.c;
endmodule

// File: rtl/mtd_checker.sv
module mtd_checker #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  feat_a,
    input logic [N-1:0]  feat_b,
    input logic [N-1:0]  feat_c,
    input logic          found,
    input logic [IW-1:0] wit_a,
    input logic [IW-1:0] wit_b,
    input logic [IW-1:0] wit_c
);
    logic [N-1:0] a_d, b_d, c_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_d <= '0;
            b_d <= '0;
            c_d <= '0;
        end else begin
            a_d <= feat_a;
            b_d <= feat_b;
            c_d <= feat_c;
        end
    end

    // R7: no match leaves the witness at zero
    p_zero_witness_r7: assert property (@(posedge clk) disable iff (rst)
        !found |-> (wit_a == '0 && wit_b == '0 && wit_c == '0));

    // R5: reported center lies exactly midway
    p_midway_r5: assert property (@(posedge clk) disable iff (rst)
        found |-> ({1'b0, wit_a} + {1'b0, wit_b} == {wit_c, 1'b0}));

    // R5: reported flags were present in the sampled inputs
    p_flags_r5: assert property (@(posedge clk) disable iff (rst)
        found |-> (a_d[wit_a] && b_d[wit_b] && c_d[wit_c]));

    // R1: no C flag anywhere means no match
    p_needs_c_r1: assert property (@(posedge clk) disable iff (rst)
        (c_d == '0) |-> !found);

    // R8: first cycle after reset shows a cleared output
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !found);
endmodule

bind midpoint_triple_detect mtd_checker #(.N(N), .IW(IW)) u_mtd_checker (
    .clk    (clk),
    .rst    (rst),
    .feat_a (feat_a),
    .feat_b (feat_b),
    .feat_c (feat_c),
    .found  (found),
    .wit_a  (wit_a),
    .wit_b  (wit_b),
    .wit_c  (wit_c)
);

// File: tb/midpoint_triple_detect_test.sv
module midpoint_triple_detect_test;
    localparam int N  = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  feat_a = '0, feat_b = '0, feat_c = '0;
    logic          found;
    logic [IW-1:0] wit_a, wit_b, wit_c;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    midpoint_triple_detect #(.N(N)) uut (
        .clk(clk), .rst(rst),
        .feat_a(feat_a), .feat_b(feat_b), .feat_c(feat_c),
        .found(found), .wit_a(wit_a), .wit_b(wit_b), .wit_c(wit_c)
    );

    // Brute-force reference with the stated priority
    task automatic model(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [N-1:0] c,
                         output bit h, output int ea, output int eb, output int ec);
        h = 0; ea = 0; eb = 0; ec = 0;
        for (int k = 0; k < N && !h; k++) begin
            for (int d = 0; d < N && !h; d++) begin
                if (k - d >= 0 && k + d < N && c[k]) begin
                    if (a[k-d] && b[k+d]) begin
                        h = 1; ea = k - d; eb = k + d; ec = k;
                    end else if (a[k+d] && b[k-d]) begin
                        h = 1; ea = k + d; eb = k - d; ec = k;
                    end
                end
            end
        end
    endtask

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input string req, input logic [N-1:0] a,
                         input logic [N-1:0] b, input logic [N-1:0] c);
        bit h; int ea, eb, ec;
        @(negedge clk);
        feat_a = a; feat_b = b; feat_c = c;
        model(a, b, c, h, ea, eb, ec);
        @(negedge clk);   // one rising edge in between
        check({req, " found"}, int'(found), int'(h));
        check({req, " wit_a"}, int'(wit_a), ea);
        check({req, " wit_b"}, int'(wit_b), eb);
        check({req, " wit_c"}, int'(wit_c), ec);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        feat_a = '1; feat_b = '1; feat_c = '1;
        @(negedge clk);
        check("R8 reset found", int'(found), 0);
        check("R8 reset wit_c", int'(wit_c), 0);
        rst = 1'b0;

        // R1 R2 R3 R4: single pair over every ordered location pair, C everywhere
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                apply("R1/R2/R3/R4 pair sweep", N'(1) << i, N'(1) << j, '1);
                check("R2 odd sum rejected", int'(found), int'((i + j) % 2 == 0));
            end

        // R1: C one location above the midpoint must not match
        for (int i = 0; i < N; i++)
            for (int j = i; j < N; j += 2)
                if ((i + j) / 2 + 1 < N)
                    apply("R1 shifted C", N'(1) << i, N'(1) << j, N'(1) << ((i + j) / 2 + 1));

        // R10: map ends
        apply("R10 low end", N'(1), N'(1) << (N - 2), N'(1) << ((N - 2) / 2));
        apply("R10 high end", N'(1) << (N - 1), N'(1) << 1, N'(1) << (N / 2));
        apply("R10 full span odd", N'(1), N'(1) << (N - 1), '1);
        apply("R4 same spot", N'(1) << 5, N'(1) << 5, N'(1) << 5);

        // R6: orientation tie at equal distance, A-low preferred
        apply("R6 tie", (N'(1) << 3) | (N'(1) << 7), (N'(1) << 3) | (N'(1) << 7), N'(1) << 5);
        // R6: smaller distance wins at same center
        apply("R6 distance", (N'(1) << 2) | (N'(1) << 6), (N'(1) << 12) | (N'(1) << 8), N'(1) << 7);

        // R5 R6 R9: pseudo-random patterns of varying density
        for (int t = 0; t < 3000; t++) begin
            logic [N-1:0] ra, rb, rc;
            ra = N'($urandom) & N'($urandom) ;
            rb = N'($urandom) & N'($urandom);
            rc = (t % 2 == 0) ? N'($urandom) & N'($urandom) & N'($urandom) : N'($urandom);
            apply("R5/R6/R9 random", ra, rb, rc);
        end

        // R7: no match leaves witness zero
        apply("R7 empty", '0, '0, '0);
        apply("R7 no C", '1, '1, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule